// File: doc/BRIEF.md
# Receive Frame FIFO with Length Header

This block sits between the byte output of an Ethernet receive path and a processor read port. It takes each received frame as a stream of bytes, from the first destination-address byte through the last frame-check byte. It packs the bytes into 32-bit words in a block-RAM FIFO and keeps a count of the complete frames that are waiting to be read. The first word of every stored frame carries the frame length in its low half and the first two destination bytes in its upper half. The processor therefore learns the size of a frame from the first word it reads.

A frame becomes visible to the read side only once its last byte has been stored and accepted. Frames are rewound and leave nothing in the FIFO in any of these cases:

- the frame does not fit in the free space;
- the frame is shorter than the minimum length;
- the frame is marked with a physical-layer error;
- the frame has a bad CRC while bad-CRC dropping is enabled.

Two sticky flags report overflow and receive errors. A flush input empties the FIFO, clears the frame count and clears both flags. A receive-enable input gates the byte stream. The source must leave at least one idle cycle after the last byte of a frame, so that the header word can be written.

Top module: `rx_frame_fifo`

## Requirements
- R1: The first stored word of a frame holds the length field in bits 15:0, the first received byte in bits 23:16 and the second received byte in bits 31:24.
- R2: The length field equals the number of received bytes of the frame plus 2.
- R3: Bytes from the third onward are packed four per word, in arrival order, with the earliest byte in bits 7:0. The unused upper bytes of a final partial word read as zero.
- R4: A frame can be read only after it is committed: its word count becomes readable and `pkt_count` increments on the second rising edge after its last byte. A read request with no committed word gives `rd_valid` low. Read data appears with `rd_valid` one cycle after `rd_en`.
- R5: `pkt_count` decrements one cycle after the final word of a frame is presented on `rd_data`. `pkt_avail` is high exactly when `pkt_count` is nonzero.
- R6: A frame that needs more words than are free (one header word plus ceil((bytes-2)/4) data words) is discarded whole, and `ovf_flag` is set until a flush. Earlier frames are read back unchanged. A frame that fills the FIFO exactly is kept.
- R7: A frame with `in_crc_bad` high on its last byte sets `err_flag`. It is discarded when `drop_bad_crc` is high and kept when it is low.
- R8: A frame shorter than MIN_BYTES bytes (default 6), or one during which `in_phy_err` was high on any byte, is discarded and sets `err_flag`.
- R9: A flush empties the FIFO and clears `pkt_count`, `pkt_avail`, `ovf_flag`, `err_flag` and `rd_valid`.
- R10: Bytes presented while `rx_en` is low are ignored. They store nothing and change no count or flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Accept incoming bytes when high |
| drop_bad_crc | input | 1 | Discard frames flagged with a bad CRC |
| fifo_flush | input | 1 | Empty the FIFO, clear count and flags |
| in_valid | input | 1 | A receive byte is present |
| in_data | input | 8 | Receive byte |
| in_last | input | 1 | This byte is the last of its frame |
| in_crc_bad | input | 1 | CRC failure indication, valid with in_last |
| in_phy_err | input | 1 | Physical-layer error on this byte |
| rd_en | input | 1 | Read request for the next committed word |
| rd_valid | output | 1 | rd_data holds a word read by the previous request |
| rd_data | output | 32 | Read word |
| pkt_count | output | CW (7 by default) | Number of complete frames not yet fully read |
| pkt_avail | output | 1 | At least one frame is available |
| ovf_flag | output | 1 | Sticky: a frame was discarded for lack of space |
| err_flag | output | 1 | Sticky: a short, PHY-error or bad-CRC frame was seen |

## Verification
The following are checked by assertions on every cycle:

- `pkt_avail` agrees with `pkt_count`;
- the count moves by at most one per cycle;
- a zero count means the read pointer has reached the commit pointer;
- a flush leaves every status output cleared;
- the write cursor stays still while receive is disabled;
- overflow rises only when the FIFO is full;
- the source leaves the required idle cycle after each frame.

Only the bench scenarios can show the rest. These are the exact word layout, the length value and zero padding for each remainder of frame length modulo four, and the rewinding of discarded frames without leftover words. The exact-fill boundary against the one-frame-too-many case, and the commit and read latencies, also need the scenarios.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef logic [31:0] word_t;
  typedef struct packed {
    logic  last;
    word_t data;
  } slot_t;
  localparam int SLOT_W = $bits(slot_t);
endpackage

// File: rtl/rxf_ram.sv
module rxf_ram #(
  parameter int AW = 6,
  parameter int DW = 33,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) q <= mem[ra];
  end
endmodule

// File: rtl/rxf_packer.sv
module rxf_packer #(
  parameter int LEN_W     = 16,
  parameter int MIN_BYTES = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             byte_ok,
  input  logic [7:0]       byte_in,
  input  logic             byte_last,
  output logic             frm_first,
  output logic             w_go,
  output logic [31:0]      w_word,
  output logic [LEN_W-1:0] frm_len,
  output logic             frm_runt,
  output logic [7:0]       hdr_b0,
  output logic [7:0]       hdr_b1
);
  logic [LEN_W-1:0] idx;
  logic [LEN_W-1:0] idx_m2;
  logic [23:0]      acc;
  logic [1:0]       lane;
  logic             in_body;

  assign idx_m2    = idx - LEN_W'(2);
  assign lane      = idx_m2[1:0];
  assign in_body   = (idx >= LEN_W'(2));
  assign frm_first = (idx == '0);
  assign w_go      = byte_ok && in_body && (byte_last || lane == 2'd3);
  assign frm_len   = idx + LEN_W'(3);
  assign frm_runt  = (32'(idx) + 32'd1) < 32'(MIN_BYTES);

  always_comb begin
    case (lane)
      2'd0:    w_word = {24'd0, byte_in};
      2'd1:    w_word = {16'd0, byte_in, acc[7:0]};
      2'd2:    w_word = {8'd0, byte_in, acc[15:0]};
      default: w_word = {byte_in, acc};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      idx    <= '0;
      acc    <= '0;
      hdr_b0 <= '0;
      hdr_b1 <= '0;
    end else if (byte_ok) begin
      if (idx == LEN_W'(0)) hdr_b0 <= byte_in;
      if (idx == LEN_W'(1)) hdr_b1 <= byte_in;
      if (byte_last) begin
        idx <= '0;
        acc <= '0;
      end else begin
        idx <= idx + LEN_W'(1);
        if (in_body) begin
          if (lane == 2'd3) acc <= '0;
          else              acc[lane*8 +: 8] <= byte_in;
        end
      end
    end
  end
endmodule

// File: rtl/rx_frame_fifo.sv
module rx_frame_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int MIN_BYTES = 6,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_en,
  input  logic          drop_bad_crc,
  input  logic          fifo_flush,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic          in_crc_bad,
  input  logic          in_phy_err,
  input  logic          rd_en,
  output logic          rd_valid,
  output logic [31:0]   rd_data,
  output logic [CW-1:0] pkt_count,
  output logic          pkt_avail,
  output logic          ovf_flag,
  output logic          err_flag
);
  localparam int LEN_W = 16;

  logic             byte_ok;
  logic             frm_first, w_go, frm_runt;
  logic [31:0]      w_word;
  logic [LEN_W-1:0] frm_len;
  logic [7:0]       hdr_b0, hdr_b1;

  logic [AW:0]      wr_cur, frm_base, cmt_ptr, rd_ptr, used;
  logic             full, dropping, frm_phy, pend_commit;
  logic [LEN_W-1:0] hdr_len;
  logic             needs_slot, hit_full, wr_adv, phy_any, discard;
  logic [AW:0]      base_now;
  logic             re, we;
  logic [AW-1:0]    wa;
  slot_t            wd, q;
  logic             inc, dec;
  logic [CW-1:0]    cnt_nx;

  assign byte_ok = in_valid && rx_en && !fifo_flush;

  rxf_packer #(.LEN_W(LEN_W), .MIN_BYTES(MIN_BYTES)) u_pack (
    .clk(clk), .rst(rst), .flush(fifo_flush), .byte_ok(byte_ok),
    .byte_in(in_data), .byte_last(in_last), .frm_first(frm_first),
    .w_go(w_go), .w_word(w_word), .frm_len(frm_len), .frm_runt(frm_runt),
    .hdr_b0(hdr_b0), .hdr_b1(hdr_b1)
  );

  assign used       = wr_cur - rd_ptr;
  assign full       = used[AW];
  assign needs_slot = byte_ok && (frm_first || w_go);
  assign hit_full   = needs_slot && full && !dropping;
  assign wr_adv     = needs_slot && !full && !dropping;
  assign phy_any    = frm_phy || in_phy_err;
  assign discard    = dropping || hit_full || frm_runt || phy_any ||
                      (in_crc_bad && drop_bad_crc);
  assign base_now   = frm_first ? wr_cur : frm_base;

  always_comb begin
    if (pend_commit) begin
      we = 1'b1;
      wa = frm_base[AW-1:0];
      wd = '{last: 1'b0, data: {hdr_b1, hdr_b0, hdr_len}};
    end else begin
      we = wr_adv && w_go;
      wa = wr_cur[AW-1:0];
      wd = '{last: in_last, data: w_word};
    end
  end

  assign re = rd_en && (rd_ptr != cmt_ptr) && !fifo_flush;

  rxf_ram #(.AW(AW), .DW(SLOT_W)) u_ram (
    .clk(clk), .we(we), .wa(wa), .wd(wd), .re(re), .ra(rd_ptr[AW-1:0]), .q(q)
  );

  assign rd_data = q.data;
  assign inc     = pend_commit;
  assign dec     = rd_valid && q.last;
  assign cnt_nx  = pkt_count + CW'(inc) - CW'(dec);

  always_ff @(posedge clk) begin
    if (rst || fifo_flush) begin
      wr_cur      <= '0;
      frm_base    <= '0;
      cmt_ptr     <= '0;
      rd_ptr      <= '0;
      dropping    <= 1'b0;
      frm_phy     <= 1'b0;
      pend_commit <= 1'b0;
      hdr_len     <= '0;
      rd_valid    <= 1'b0;
      pkt_count   <= '0;
      pkt_avail   <= 1'b0;
      ovf_flag    <= 1'b0;
      err_flag    <= 1'b0;
    end else begin
      pend_commit <= 1'b0;
      rd_valid    <= re;
      pkt_count   <= cnt_nx;
      pkt_avail   <= (cnt_nx != '0);
      if (re) rd_ptr <= rd_ptr + 1'b1;
      if (pend_commit) cmt_ptr <= wr_cur;
      if (byte_ok) begin
        if (frm_first) frm_base <= wr_cur;
        if (wr_adv) wr_cur <= wr_cur + 1'b1;
        if (hit_full) begin
          dropping <= 1'b1;
          ovf_flag <= 1'b1;
        end
        if (in_phy_err) frm_phy <= 1'b1;
        if (in_last) begin
          dropping <= 1'b0;
          frm_phy  <= 1'b0;
          if (frm_runt || phy_any || in_crc_bad) err_flag <= 1'b1;
          if (discard) wr_cur <= base_now;
          else begin
            pend_commit <= 1'b1;
            hdr_len     <= frm_len;
          end
        end
      end
    end
  end

  // R5: availability follows the count
  a_r5_avail_matches_count: assert property (@(posedge clk) disable iff (rst)
    pkt_avail == (pkt_count != '0));

  // R5: the count moves by at most one frame per cycle
  a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
    !$past(fifo_flush) |-> ((pkt_count == $past(pkt_count)) ||
                            (pkt_count == $past(pkt_count) + 1'b1) ||
                            (pkt_count == $past(pkt_count) - 1'b1)));

  // R4: with no frames counted, nothing committed is left to read
  a_r4_empty_no_data: assert property (@(posedge clk) disable iff (rst)
    (pkt_count == '0) |-> (rd_ptr == cmt_ptr));

  // R4: source leaves an idle cycle for the header write
  a_r4_commit_gap: assert property (@(posedge clk) disable iff (rst)
    pend_commit |-> !(in_valid && rx_en));

  // R6: overflow rises only when the FIFO was full
  a_r6_ovf_when_full: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> $past(full));

  // R9: flush clears every status output
  a_r9_flush_clears: assert property (@(posedge clk) disable iff (rst)
    $past(fifo_flush) |-> (pkt_count == '0 && !pkt_avail && !ovf_flag &&
                           !err_flag && !rd_valid));

  // R10: with receive disabled the write cursor does not move
  a_r10_rx_off_still: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && !fifo_flush) |=> (wr_cur == $past(wr_cur)));
endmodule

// File: tb/rx_frame_fifo_tb.sv
module rx_frame_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int CW = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_en = 1'b1, drop_bad_crc = 1'b0, fifo_flush = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, in_crc_bad = 1'b0, in_phy_err = 1'b0;
  logic [7:0] in_data = '0;
  logic rd_en = 1'b0;
  logic rd_valid, pkt_avail, ovf_flag, err_flag;
  logic [31:0] rd_data;
  logic [CW-1:0] pkt_count;

  int checks = 0;
  int fails = 0;
  logic [7:0] fb [128];
  logic [31:0] exp_q [$];
  int pk_q [$];
  int used_words = 0;
  bit exp_ovf = 0, exp_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_fifo #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .drop_bad_crc(drop_bad_crc),
    .fifo_flush(fifo_flush), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_crc_bad(in_crc_bad), .in_phy_err(in_phy_err),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
    .pkt_count(pkt_count), .pkt_avail(pkt_avail), .ovf_flag(ovf_flag),
    .err_flag(err_flag)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int words_for(int n);
    return 1 + (n - 2 + 3) / 4;
  endfunction

  task automatic model_push(int n);
    exp_q.push_back({fb[1], fb[0], 16'(n + 2)});
    for (int i = 2; i < n; i += 4) begin
      logic [31:0] w = '0;
      for (int j = 0; j < 4; j++)
        if (i + j < n) w[8*j +: 8] = fb[i + j];
      exp_q.push_back(w);
    end
    pk_q.push_back(words_for(n));
    used_words += words_for(n);
  endtask

  // drive frame of n bytes from fb; update model
  task automatic send_frame(int n, bit crc_bad, bit phy, bit en);
    bit runt = (n < 6);
    bit nofit = (used_words + words_for(n) > DEPTH);
    for (int i = 0; i < n; i++) fb[i] = 8'($urandom);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_en      = en;
      in_valid   = 1'b1;
      in_data    = fb[i];
      in_last    = (i == n - 1);
      in_crc_bad = (i == n - 1) && crc_bad;
      in_phy_err = phy && (i == 2);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_crc_bad = 1'b0; in_phy_err = 1'b0;
    rx_en = 1'b1;
    @(negedge clk);
    if (en) begin
      if (runt || phy || crc_bad) exp_err = 1;
      if (nofit && !runt) exp_ovf = 1;
      if (!(runt || phy || nofit || (crc_bad && drop_bad_crc))) model_push(n);
    end
  endtask

  task automatic check_status(string tag);
    chk(pkt_count == CW'(pk_q.size()), {tag, " R4 count"}, 32'(pkt_count), 32'(pk_q.size()));
    chk(pkt_avail == (pk_q.size() != 0), {tag, " R5 avail"}, 32'(pkt_avail), 32'(pk_q.size() != 0));
    chk(ovf_flag == exp_ovf, {tag, " R6 ovf"}, 32'(ovf_flag), 32'(exp_ovf));
    chk(err_flag == exp_err, {tag, " R7 R8 err"}, 32'(err_flag), 32'(exp_err));
  endtask

  task automatic read_word(output logic v, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    v = rd_valid; d = rd_data;
  endtask

  task automatic drain();
    while (pk_q.size() > 0) begin
      int nw = pk_q.pop_front();
      for (int k = 0; k < nw; k++) begin
        logic v; logic [31:0] d; logic [31:0] e;
        read_word(v, d);
        e = exp_q.pop_front();
        chk(v == 1'b1, "R4 rd_valid", 32'(v), 32'd1);
        chk(d == e, (k == 0) ? "R1 R2 header word" : "R3 data word", d, e);
      end
      used_words -= nw;
      @(negedge clk);
      chk(pkt_count == CW'(pk_q.size()), "R5 count after last read", 32'(pkt_count), 32'(pk_q.size()));
    end
    begin
      logic v; logic [31:0] d;
      read_word(v, d);
      chk(v == 1'b0, "R4 empty read", 32'(v), 32'd0);
    end
  endtask

  task automatic do_flush();
    @(negedge clk); fifo_flush = 1'b1;
    @(negedge clk); fifo_flush = 1'b0;
    exp_q.delete(); pk_q.delete(); used_words = 0; exp_ovf = 0; exp_err = 0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state: R9
    chk(pkt_count == 0 && !pkt_avail && !ovf_flag && !err_flag && !rd_valid,
        "R9 reset state", {pkt_count, pkt_avail, ovf_flag, err_flag}, 32'd0);

    // layouts for each remainder: R1 R2 R3
    send_frame(14, 0, 0, 1); check_status("lay14");
    send_frame(15, 0, 0, 1); check_status("lay15");
    send_frame(16, 0, 0, 1); check_status("lay16");
    send_frame(17, 0, 0, 1); check_status("lay17");
    drain(); check_status("after drain");

    // short frame and PHY error: R8
    send_frame(4, 0, 0, 1); check_status("runt R8");
    send_frame(5, 0, 0, 1); check_status("runt5 R8");
    send_frame(6, 0, 0, 1); check_status("min6 R8");
    do_flush(); check_status("flush R9");
    send_frame(20, 0, 1, 1); check_status("phy R8");
    drain();

    // bad CRC: R7
    do_flush();
    drop_bad_crc = 1'b1;
    send_frame(22, 1, 0, 1); check_status("crc drop R7");
    drop_bad_crc = 1'b0;
    send_frame(23, 1, 0, 1); check_status("crc keep R7");
    drain();

    // receive disabled: R10
    do_flush();
    send_frame(18, 0, 0, 0); check_status("rx off R10");
    drain();

    // random frames with read-back
    for (int r = 0; r < 24; r++) begin
      int n = 6 + int'($urandom_range(0, 40));
      bit cb = ($urandom_range(0, 3) == 0);
      drop_bad_crc = $urandom_range(0, 1) == 1;
      send_frame(n, cb, 0, 1);
      check_status("random");
      if ($urandom_range(0, 1) == 1) drain();
    end
    drain();

    // overflow boundary: R6
    do_flush();
    drop_bad_crc = 1'b0;
    for (int f = 0; f < 8; f++) send_frame(30, 0, 0, 1);
    check_status("exact fill R6");
    send_frame(30, 0, 0, 1); check_status("one too many R6");
    drain(); check_status("after ovf drain R6");
    send_frame(12, 0, 0, 1); check_status("refill R6");
    drain();

    // flush with content: R9
    send_frame(19, 0, 0, 1);
    send_frame(21, 0, 0, 1);
    do_flush(); check_status("flush content R9");
    begin
      logic v; logic [31:0] d;
      read_word(v, d);
      chk(v == 1'b0, "R9 read after flush", 32'(v), 32'd0);
    end

    finish_run();
  end
endmodule